// File: doc/BRIEF.md
# Character Display Host Write Port

This block is the processor-facing side of an eight-digit dot-matrix character display controller. A host writes bytes over one 8-bit parallel bus, qualified by an active-low chip select and an active-low write strobe. A 3-bit digit address, a store-select address bit and an active-low blink-access pin together decide which of three stores the byte goes to. The three stores are an eight-entry character memory, an eight-entry one-bit blink memory, and a single 8-bit attribute register.

Each character entry holds a 7-bit character code in bits 6..0. Bit 7 picks one of two 128-glyph font pages. The scan side reads a character entry and its blink bit through a digit index of its own, and it reads the attribute register directly. The font lookup, row scanning and LED drive sit downstream and are not part of this block.

Top module: `disp_host_port`

## Requirements
- R1: With `blink_n` high and `sel_char` = 1, a write stores the full `wdata` byte into the character entry chosen by `digit_addr`. Bits 6..0 are the code and bit 7 is the page bit (0 = first page, 1 = second page). No other entry changes.
- R2: With `blink_n` high and `sel_char` = 0, a write loads the full `wdata` byte into the attribute register, and the character and blink memories stay unchanged.
- R3: With `blink_n` low, a write sets the blink bit of the digit chosen by `digit_addr` to `wdata[0]`, whatever `sel_char` is. Character memory and the attribute register are left unchanged.
- R4: While `rst_n` is low at a rising edge, every character entry becomes 0x20 (blank), every blink bit becomes 0, and the attribute register becomes 0x00.
- R5: No store changes unless `cs_n` and `wr_n` are both low.
- R6: A write happens only on the first rising edge at which `cs_n` and `wr_n` are both seen low. If both stay low, no further write happens, even when the data or address changes. A strobe that is already active when reset is released causes no write.
- R7: Reset takes priority over a write presented at the same edge.
- R8: `scan_char` and `scan_blink` show, combinationally, the entry selected by `scan_addr`. `attr` shows the attribute register at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all stores update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| sel_char | input | 1 | Store select: 1 = character memory, 0 = attribute register |
| blink_n | input | 1 | Active-low blink memory access; overrides `sel_char` |
| digit_addr | input | 3 | Host digit address |
| wdata | input | 8 | Host write data |
| scan_addr | input | 3 | Scan-side digit index |
| scan_char | output | 8 | Character entry at `scan_addr` |
| scan_blink | output | 1 | Blink bit at `scan_addr` |
| attr | output | 8 | Attribute register |

## Verification
The bench holds the strobe low across several cycles while it changes the data and address, so a level-triggered design would overwrite the entry and be caught. It writes with `blink_n` low and `sel_char` at both values, and then reads every character entry and the attribute register back, which exposes a decoder that lets the store-select bit win over the blink pin. It also asserts reset together with a write and releases reset with the strobe already active. A design that clears the character memory to zero, lets the write beat reset, or treats the still-active strobe as a new write shows the wrong value at the read ports.

// File: rtl/disp_host_port.sv
module disp_host_port #(
  parameter int DIGITS = 8,
  parameter int DW     = 8,
  parameter logic [DW-1:0] BLANK = 8'h20,
  localparam int AW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          sel_char,
  input  logic          blink_n,
  input  logic [AW-1:0] digit_addr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] scan_addr,
  output logic [DW-1:0] scan_char,
  output logic          scan_blink,
  output logic [DW-1:0] attr
);

  logic [DIGITS-1:0][DW-1:0] chr_q;
  logic [DIGITS-1:0]         blk_q;
  logic [DW-1:0]             attr_q;
  logic                      strb, strb_q, fire;

  assign strb = ~cs_n & ~wr_n;
  assign fire = strb & ~strb_q;

  always_ff @(posedge clk) strb_q <= strb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DIGITS; i++) chr_q[i] <= BLANK;
      blk_q  <= '0;
      attr_q <= '0;
    end else if (fire) begin
      if (!blink_n)      blk_q[digit_addr] <= wdata[0];
      else if (sel_char) chr_q[digit_addr] <= wdata;
      else               attr_q            <= wdata;
    end
  end

  assign scan_char  = chr_q[scan_addr];
  assign scan_blink = blk_q[scan_addr];
  assign attr       = attr_q;

  p_reset_clear_r4: assert property (@(posedge clk)
    !rst_n |=> (attr_q == '0) && (blk_q == '0) && (chr_q[0] == BLANK));

  p_no_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || wr_n) |=> $stable(chr_q) && $stable(blk_q) && $stable(attr_q));

  p_held_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && strb_q) |=> $stable(chr_q) && $stable(blk_q) && $stable(attr_q));

  p_blink_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_n |=> $stable(chr_q) && $stable(attr_q));

  p_attr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && blink_n && !sel_char) |=> (attr_q == $past(wdata)) && $stable(chr_q));

endmodule

// File: tb/disp_host_port_tb.sv
`timescale 1ns/1ps
module disp_host_port_tb;
  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, sel_char = 0, blink_n = 1;
  logic [2:0] digit_addr = 0, scan_addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] scan_char, attr;
  logic scan_blink;
  int checks = 0, errors = 0;
  logic [7:0] m_chr [8];
  logic       m_blk [8];
  logic [7:0] m_attr;

  always #2 clk = ~clk;

  disp_host_port u_dut (.clk, .rst_n, .cs_n, .wr_n, .sel_char, .blink_n,
    .digit_addr, .wdata, .scan_addr, .scan_char, .scan_blink, .attr);

  function automatic logic [7:0] exp_chr(int a); return m_chr[a]; endfunction
  function automatic logic exp_blk(int a); return m_blk[a]; endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_chr[i] = 8'h20; m_blk[i] = 0; end
    m_attr = 0;
  endtask

  task automatic model_write(logic s, logic f, logic [2:0] a, logic [7:0] d);
    if (!f) m_blk[a] = d[0];
    else if (s) m_chr[a] = d;
    else m_attr = d;
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 8; i++) begin
      scan_addr = 3'(i);
      #0.1;
      checks++;
      if (scan_char !== exp_chr(i) || scan_blink !== exp_blk(i)) begin
        errors++;
        $display("FAIL %s digit %0d char %h blink %b expected %h %b", req, i,
                 scan_char, scan_blink, exp_chr(i), exp_blk(i));
      end
    end
    checks++;
    if (attr !== m_attr) begin
      errors++;
      $display("FAIL %s attr %h expected %h", req, attr, m_attr);
    end
  endtask

  task automatic wr(logic s, logic f, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    sel_char = s; blink_n = f; digit_addr = a; wdata = d; cs_n = 0; wr_n = 0;
    @(negedge clk);
    cs_n = 1; wr_n = 1; blink_n = 1;
    model_write(s, f, a, d);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R4 reset");
    rst_n = 1;
    @(negedge clk);
    // R1 and R8: code plus page bit
    wr(1, 1, 3, 8'hC1); wr(1, 1, 7, 8'h41); check_all("R1 char write");
    wr(0, 1, 5, 8'h5A); check_all("R2 attr write");
    // R3: blink overrides sel_char
    wr(1, 0, 3, 8'hFF); wr(0, 0, 6, 8'h01); wr(1, 0, 3, 8'h00); wr(0, 0, 2, 8'h03);
    check_all("R3 blink access");
    // R5: only one of the two strobes low
    @(negedge clk); sel_char = 1; digit_addr = 1; wdata = 8'h99; cs_n = 0; wr_n = 1;
    @(negedge clk); cs_n = 1; wr_n = 0; sel_char = 0;
    @(negedge clk); wr_n = 1;
    check_all("R5 partial strobe");
    // R6: held strobe with changing data
    @(negedge clk); sel_char = 1; blink_n = 1; digit_addr = 4; wdata = 8'h33; cs_n = 0; wr_n = 0;
    model_write(1, 1, 4, 8'h33);
    @(negedge clk); wdata = 8'h77; digit_addr = 0;
    @(negedge clk); sel_char = 0; wdata = 8'hEE;
    @(negedge clk); blink_n = 0; digit_addr = 4; wdata = 8'h01;
    @(negedge clk); cs_n = 1; wr_n = 1; blink_n = 1;
    check_all("R6 held strobe");
    // R7: reset with write at same edge; R6 strobe held across reset release
    @(negedge clk); rst_n = 0; sel_char = 1; digit_addr = 2; wdata = 8'h55; cs_n = 0; wr_n = 0;
    model_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk); cs_n = 1; wr_n = 1;
    check_all("R7 reset priority");
    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r = $urandom;
      wr(r[0], r[2:1] != 0, r[5:3], r[13:6]);
      if (r[20:18] == 0) check_all("R1 R2 R3 random");
    end
    check_all("R8 final readout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule